// File: doc/BRIEF.md
# Table-Jump Target Resolver

This block turns a compressed table-jump request into a jump target address. A caller hands it an 8-bit table index together with several other inputs:

- the current value of the jump-table control register;
- a width selector that says whether the hart runs with 32-bit or 64-bit registers;
- a grant from the state-enable logic, with the exception cause to report if that grant is withheld.

All of these are captured on a single-cycle `start` strobe. The block then checks in a fixed order whether the request may proceed. If it may, it reads one table entry over a simple instruction-side request/acknowledge port. It returns that entry with bit 0 cleared as the target. If it may not, it returns an exception cause instead.

Completion is marked by a one-cycle `done` pulse. During that pulse exactly one of `tgt_valid` and `exc_valid` is high. The caller uses the result to redirect the program counter and write the link register. Both of those actions, and instruction decode, belong to the caller.

Top module: `tbljmp_resolver`

## Requirements
- R1: When `perm_ok` is low at `start`, the block finishes with `exc_valid` high and `exc_cause` equal to the `perm_cause` captured at `start`, and asserts no `mem_req` for that request.
- R2: When permission is granted but the mode field (control register bits [5:0]) is nonzero, the block finishes with `exc_valid` high and `exc_cause` = 2 (illegal instruction), and asserts no `mem_req`.
- R3: The permission check takes precedence over the mode check: with both conditions failing, the reported cause is `perm_cause`.
- R4: With `wide_mode` = 1, `mem_addr` = (control & ~0x3F) + index*8, computed over 64 bits, and `mem_dword` = 1.
- R5: With `wide_mode` = 0, `mem_addr` = ((control[31:0] & ~0x3F) + index*4) mod 2^32, zero-extended to 64 bits, and `mem_dword` = 0; control bits [63:32] have no effect.
- R6: On a fault-free acknowledge, `target` equals the read data with bit 0 forced to 0; with `wide_mode` = 0 only `mem_rdata[31:0]` is used, and `target[63:32]` is zero.
- R7: If `mem_fault` is high with `mem_ack`, the block reports `exc_cause` = 1 (instruction access fault) instead of a target.
- R8: Once raised, `mem_req` stays high with `mem_addr` and `mem_dword` unchanged until `mem_ack`, and each request receives exactly one acknowledged transfer.
- R9: `done` is a one-cycle pulse; during it exactly one of `tgt_valid`/`exc_valid` is high, and neither is high outside it.
- R10: A `start` pulse while a request is in progress is ignored: it produces no extra `done` and does not change the result.
- R11: After reset, `done`, `tgt_valid`, `exc_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe, accepted only while idle |
| index | input | 8 | Table index |
| ctrl | input | 64 | Jump-table control register (mode in [5:0], base above) |
| wide_mode | input | 1 | 1 = 64-bit registers, 0 = 32-bit |
| perm_ok | input | 1 | State-enable grant for the control register |
| perm_cause | input | 5 | Cause reported when the grant is withheld |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 64 | Entry byte address |
| mem_dword | output | 1 | Read size: 1 = 8 bytes, 0 = 4 bytes |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 64 | Read data |
| mem_fault | input | 1 | Access fault flag, valid with `mem_ack` |
| done | output | 1 | Completion pulse |
| tgt_valid | output | 1 | `target` is valid (during `done`) |
| target | output | 64 | Jump target |
| exc_valid | output | 1 | `exc_cause` is valid (during `done`) |
| exc_cause | output | 5 | Exception cause |

## Verification
A sequencer that takes the wrong branch in its check state shows at the ports on the very next cycle. It either raises `mem_req` for a rejected request or finishes with the wrong cause. The bench therefore counts every request cycle and every acknowledge of each operation. A corrupted captured operand or a wrong address scale shows as a mismatching `mem_addr` in the first request cycle. It is compared again on every wait cycle, so drift is caught one cycle after it happens. A stuck or repeated `done` shows within one cycle of the expected pulse.

// File: rtl/tj_pkg.sv
// Shared types and constants for the table-jump resolver.
// Assumes cause codes fit in 5 bits.
package tj_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } tj_state_e;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_FAULT = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL     = 5'd2;
endpackage

// File: rtl/tj_addr_gen.sv
// Entry address generator: strips the mode field, scales the index by the
// entry size and adds it to the base. In narrow mode the sum wraps at 32 bits
// and is zero-extended. Also flags a nonzero mode field.
// Assumes XLEN_W >= NARROW_W + 1 and purely combinational use.
module tj_addr_gen #(
    parameter int XLEN_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IDX_W    = 8,
    parameter int MODE_W   = 6
) (
    input  logic [XLEN_W-1:0] ctrl,
    input  logic [IDX_W-1:0]  index,
    input  logic              wide_mode,
    output logic [XLEN_W-1:0] addr,
    output logic              mode_bad
);
    localparam int WIDE_SH   = 3;
    localparam int NARROW_SH = 2;

    logic [XLEN_W-1:0]   base_w;
    logic [XLEN_W-1:0]   off_w;
    logic [NARROW_W-1:0] off_n;
    logic [XLEN_W-1:0]   sum_w;
    logic [NARROW_W-1:0] sum_n;

    // Mode check and base extraction.
    always_comb begin
        mode_bad = |ctrl[MODE_W-1:0];
        base_w   = {ctrl[XLEN_W-1:MODE_W], {MODE_W{1'b0}}};
    end

    // Scaled offsets for both entry sizes.
    always_comb begin
        off_w = {{(XLEN_W-IDX_W-WIDE_SH){1'b0}}, index, {WIDE_SH{1'b0}}};
        off_n = {{(NARROW_W-IDX_W-NARROW_SH){1'b0}}, index, {NARROW_SH{1'b0}}};
    end

    // Address sum per width, narrow one wrapping at NARROW_W bits.
    always_comb begin
        sum_w = base_w + off_w;
        sum_n = base_w[NARROW_W-1:0] + off_n;
        addr  = wide_mode ? sum_w : {{(XLEN_W-NARROW_W){1'b0}}, sum_n};
    end
endmodule

// File: rtl/tj_target_fmt.sv
// Target formatter: selects the entry width, zero-extends a narrow entry and
// clears bit 0. Combinational only.
module tj_target_fmt #(
    parameter int XLEN_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [XLEN_W-1:0] rdata,
    input  logic              wide_mode,
    output logic [XLEN_W-1:0] target
);
    // Width selection and low-bit clearing.
    always_comb begin
        if (wide_mode) begin
            target = {rdata[XLEN_W-1:1], 1'b0};
        end else begin
            target = {{(XLEN_W-NARROW_W){1'b0}}, rdata[NARROW_W-1:1], 1'b0};
        end
    end
endmodule

// File: rtl/tj_ctrl.sv
// Sequencer for one table-jump resolution: IDLE -> CHECK -> (REQ -> WAIT*) ->
// DONE -> IDLE. Checks the permission grant first, then the mode field, and
// only then reads. Holds the result until the done cycle.
// Assumes its operands are held stable by the caller from launch to done.
module tj_ctrl
    import tj_pkg::*;
#(
    parameter int XLEN_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               perm_ok,
    input  logic [CAUSE_W-1:0] perm_cause,
    input  logic               mode_bad,
    input  logic               mem_ack,
    input  logic               mem_fault,
    input  logic [XLEN_W-1:0]  fmt_target,
    output logic               launch,
    output logic               mem_req,
    output logic               done,
    output logic               tgt_valid,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN_W-1:0]  target
);
    tj_state_e          st, st_nx;
    logic               exc_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [XLEN_W-1:0]  tgt_q;

    // Next-state selection.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = ST_CHECK;
            ST_CHECK: st_nx = (!perm_ok || mode_bad) ? ST_DONE : ST_REQ;
            ST_REQ:   st_nx = mem_ack ? ST_DONE : ST_WAIT;
            ST_WAIT:  if (mem_ack) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Result capture: rejection in CHECK, read outcome on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q   <= 1'b0;
            cause_q <= '0;
            tgt_q   <= '0;
        end else if (st == ST_CHECK && !perm_ok) begin
            exc_q   <= 1'b1;
            cause_q <= perm_cause;
            tgt_q   <= '0;
        end else if (st == ST_CHECK && mode_bad) begin
            exc_q   <= 1'b1;
            cause_q <= CAUSE_ILLEGAL;
            tgt_q   <= '0;
        end else if ((st == ST_REQ || st == ST_WAIT) && mem_ack) begin
            exc_q   <= mem_fault;
            cause_q <= mem_fault ? CAUSE_FETCH_FAULT : '0;
            tgt_q   <= mem_fault ? '0 : fmt_target;
        end
    end

    // Output decode.
    always_comb begin
        launch    = (st == ST_IDLE) && start;
        mem_req   = (st == ST_REQ) || (st == ST_WAIT);
        done      = (st == ST_DONE);
        tgt_valid = done && !exc_q;
        exc_valid = done && exc_q;
        exc_cause = cause_q;
        target    = tgt_q;
    end

    // A withheld grant ends the request with its own cause and no read.
    p_perm_noread_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && !perm_ok) |=> (!mem_req && exc_valid && exc_cause == $past(perm_cause)));

    // A nonzero mode with a grant ends as illegal instruction, no read.
    p_mode_noread_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && perm_ok && mode_bad) |=> (!mem_req && exc_valid && exc_cause == CAUSE_ILLEGAL));

    // A faulting acknowledge becomes an access-fault exception.
    p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_fault) |=> (exc_valid && exc_cause == CAUSE_FETCH_FAULT));

    // A request is held until acknowledged.
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    // Done never lasts two cycles.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/tbljmp_resolver.sv
// Table-jump target resolver top. Captures the operands on an accepted start,
// derives the entry address, and lets the sequencer run the checks and the read.
// Assumes mem_rdata and mem_fault are valid only while mem_ack is high.
module tbljmp_resolver
    import tj_pkg::*;
#(
    parameter int XLEN_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IDX_W    = 8,
    parameter int MODE_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [IDX_W-1:0]   index,
    input  logic [XLEN_W-1:0]  ctrl,
    input  logic               wide_mode,
    input  logic               perm_ok,
    input  logic [CAUSE_W-1:0] perm_cause,
    output logic               mem_req,
    output logic [XLEN_W-1:0]  mem_addr,
    output logic               mem_dword,
    input  logic               mem_ack,
    input  logic [XLEN_W-1:0]  mem_rdata,
    input  logic               mem_fault,
    output logic               done,
    output logic               tgt_valid,
    output logic [XLEN_W-1:0]  target,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause
);
    logic               launch;
    logic [IDX_W-1:0]   idx_q;
    logic [XLEN_W-1:0]  ctrl_q;
    logic               wide_q;
    logic               perm_q;
    logic [CAUSE_W-1:0] pcause_q;
    logic               mode_bad;
    logic [XLEN_W-1:0]  fmt_target;

    // Operand capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            ctrl_q   <= '0;
            wide_q   <= 1'b0;
            perm_q   <= 1'b0;
            pcause_q <= '0;
        end else if (launch) begin
            idx_q    <= index;
            ctrl_q   <= ctrl;
            wide_q   <= wide_mode;
            perm_q   <= perm_ok;
            pcause_q <= perm_cause;
        end
    end

    tj_addr_gen #(
        .XLEN_W  (XLEN_W),
        .NARROW_W(NARROW_W),
        .IDX_W   (IDX_W),
        .MODE_W  (MODE_W)
    ) addr_i (
        .ctrl     (ctrl_q),
        .index    (idx_q),
        .wide_mode(wide_q),
        .addr     (mem_addr),
        .mode_bad (mode_bad)
    );

    tj_target_fmt #(
        .XLEN_W  (XLEN_W),
        .NARROW_W(NARROW_W)
    ) fmt_i (
        .rdata    (mem_rdata),
        .wide_mode(wide_q),
        .target   (fmt_target)
    );

    tj_ctrl #(
        .XLEN_W(XLEN_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .perm_ok   (perm_q),
        .perm_cause(pcause_q),
        .mode_bad  (mode_bad),
        .mem_ack   (mem_ack),
        .mem_fault (mem_fault),
        .fmt_target(fmt_target),
        .launch    (launch),
        .mem_req   (mem_req),
        .done      (done),
        .tgt_valid (tgt_valid),
        .exc_valid (exc_valid),
        .exc_cause (exc_cause),
        .target    (target)
    );

    // Read size follows the captured width selector.
    always_comb mem_dword = wide_q;

    // Address and size stay put while a read waits.
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_dword)));

    // Narrow reads never address above the narrow range and are word aligned.
    p_narrow_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_dword) |-> (mem_addr[XLEN_W-1:NARROW_W] == '0 && mem_addr[1:0] == 2'b00));

    // A returned target is always even.
    p_tgt_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> !target[0]);
endmodule

// File: tb/tbljmp_resolver_tb_top.sv
module tbljmp_resolver_tb_top;
    typedef struct packed {
        logic        perm;
        logic        wide;
        logic [63:0] ctrl;
        logic [7:0]  idx;
        logic        fault;
        logic [1:0]  lat;
        logic [1:0]  kind;   // 0 target, 1 permission, 2 illegal, 3 fault
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 64'h0000_0000_8000_1000, 8'd0,   1'b0, 2'd0, 2'd0},
        '{1'b1, 1'b1, 64'h0000_0012_3456_7840, 8'd255, 1'b0, 2'd2, 2'd0},
        '{1'b1, 1'b0, 64'hFFFF_FFFF_0000_2000, 8'd7,   1'b0, 2'd1, 2'd0},
        '{1'b1, 1'b0, 64'h0000_0000_FFFF_FFC0, 8'd255, 1'b0, 2'd0, 2'd0},
        '{1'b0, 1'b1, 64'h0000_0000_0000_1000, 8'd3,   1'b0, 2'd0, 2'd1},
        '{1'b1, 1'b1, 64'h0000_0000_0000_1001, 8'd3,   1'b0, 2'd0, 2'd2},
        '{1'b0, 1'b0, 64'h0000_0000_0000_1020, 8'd3,   1'b0, 2'd0, 2'd1},
        '{1'b1, 1'b0, 64'h0000_0000_0000_4000, 8'd9,   1'b1, 2'd1, 2'd3},
        '{1'b1, 1'b1, 64'h0000_0000_0000_003F, 8'd1,   1'b0, 2'd0, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  index = '0;
    logic [63:0] ctrl = '0;
    logic        wide_mode = 1'b0;
    logic        perm_ok = 1'b0;
    logic [4:0]  perm_cause = '0;
    logic        mem_req, mem_dword, mem_ack, mem_fault;
    logic [63:0] mem_addr, mem_rdata;
    logic        done, tgt_valid, exc_valid;
    logic [63:0] target;
    logic [4:0]  exc_cause;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int ack_cnt = 0;
    int req_cnt = 0;
    int wcnt = 0;
    logic [1:0] lat_cur = '0;
    logic       fault_cur = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [63:0] memf(input logic [63:0] a);
        return {a[31:0] ^ 32'h5EED_0001, a[31:0] ^ 32'hC0DE_0F01};
    endfunction

    function automatic logic [63:0] exp_addr(input logic [63:0] c, input logic [7:0] i,
                                             input logic w);
        logic [63:0] b;
        logic [31:0] n;
        b = c & ~64'h3F;
        n = b[31:0] + {22'd0, i, 2'b00};
        return w ? (b + {53'd0, i, 3'b000}) : {32'd0, n};
    endfunction

    tbljmp_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .index(index), .ctrl(ctrl),
        .wide_mode(wide_mode), .perm_ok(perm_ok), .perm_cause(perm_cause),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_dword(mem_dword),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_fault(mem_fault),
        .done(done), .tgt_valid(tgt_valid), .target(target),
        .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    // Memory model with programmable latency.
    assign mem_ack   = mem_req && (wcnt >= int'(lat_cur));
    assign mem_rdata = memf(mem_addr);
    assign mem_fault = fault_cur && mem_ack;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        wcnt   <= (mem_req && !mem_ack) ? wcnt + 1 : 0;
        if (mem_req && mem_ack) ack_cnt <= ack_cnt + 1;
        if (mem_req) req_cnt <= req_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one vector and checks every observable result.
    task automatic run_vec(input vec_t v, input logic [4:0] pc, input bit busy_start);
        logic [63:0] ea;
        logic [63:0] et;
        int          a0, r0, waited, dcount;
        bit          got;
        @(negedge clk);
        index = v.idx; ctrl = v.ctrl; wide_mode = v.wide; perm_ok = v.perm;
        perm_cause = pc; lat_cur = v.lat; fault_cur = v.fault;
        a0 = ack_cnt; r0 = req_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // Scramble live inputs: only the captured values may matter.
        index = ~v.idx; ctrl = ~v.ctrl; wide_mode = ~v.wide; perm_ok = ~v.perm;
        ea = exp_addr(v.ctrl, v.idx, v.wide);
        et = v.wide ? (memf(ea) & ~64'h1) : {32'd0, memf(ea)[31:1], 1'b0};
        got = 1'b0; waited = 0;
        while (!got && waited < 40) begin
            if (busy_start && waited == 1) start = 1'b1;
            else start = 1'b0;
            if (mem_req) begin
                chk(mem_addr == ea, v.wide ? "R4/R8 addr" : "R5/R8 addr", mem_addr, ea);
                chk(mem_dword == v.wide, "R4/R5 size", {63'd0, mem_dword}, {63'd0, v.wide});
            end
            chk(!(tgt_valid || exc_valid) || done, "R9 valid outside done",
                {62'd0, tgt_valid, exc_valid}, 64'd0);
            if (done) got = 1'b1;
            else begin
                @(negedge clk);
                waited++;
            end
        end
        start = 1'b0;
        chk(got, "R9 done arrives", {63'd0, got}, 64'd1);
        if (got) begin
            chk((tgt_valid ^ exc_valid) == 1'b1, "R9 one valid",
                {62'd0, tgt_valid, exc_valid}, 64'd0);
            case (v.kind)
                2'd0: begin
                    chk(tgt_valid && target == et, "R6 target", target, et);
                    chk(ack_cnt - a0 == 1, "R8 one transfer", 64'(ack_cnt - a0), 64'd1);
                end
                2'd1: begin
                    chk(exc_valid && exc_cause == pc, "R1/R3 perm cause", 64'(exc_cause), 64'(pc));
                    chk(req_cnt == r0, "R1 no read", 64'(req_cnt - r0), 64'd0);
                end
                2'd2: begin
                    chk(exc_valid && exc_cause == 5'd2, "R2 illegal cause", 64'(exc_cause), 64'd2);
                    chk(req_cnt == r0, "R2 no read", 64'(req_cnt - r0), 64'd0);
                end
                default: begin
                    chk(exc_valid && exc_cause == 5'd1, "R7 fault cause", 64'(exc_cause), 64'd1);
                end
            endcase
            // Done must drop next cycle and no second done may follow.
            dcount = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done) dcount++;
            end
            chk(dcount == 0, busy_start ? "R10 no extra done" : "R9 single pulse",
                64'(dcount), 64'd0);
        end
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        start = 1'b1;   // start under reset must do nothing
        @(negedge clk);
        chk(!done && !tgt_valid && !exc_valid && !mem_req, "R11 reset state",
            {60'd0, done, tgt_valid, exc_valid, mem_req}, 64'd0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req, "R11 idle after reset", {62'd0, done, mem_req}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 5'd22, 1'b0);

        // Different permission cause value (R1).
        run_vec(VECS[4], 5'd3, 1'b0);
        // Start while busy is ignored; result must be the first request's (R10).
        run_vec(VECS[1], 5'd22, 1'b1);
        run_vec(VECS[5], 5'd22, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule